// File: doc/BRIEF.md
# Two-Bank SDRAM Command Front End

This block sits at the pin side of a two-bank synchronous DRAM model or bus monitor. On every rising clock edge it samples the active-low command strobes, the bank-select bit, the address bus and the byte-mask input, and it turns them into one decoded command. From that command stream it keeps the open or idle state and the open row of each bank. It also runs a fixed-length column burst and produces per-beat write enables and read output enables that follow the data mask.

One address bit, the auto-precharge bit, means different things for different commands. On a read or write it asks for the bank to close after the burst. On a precharge it picks between closing both banks and closing only the selected bank. The data mask acts at once on write beats but two edges late on read beats, which models the read access pipeline. Clock enable is handled only as a suspend: while it is low the block takes no command and holds everything.

Top module: `sdram_cmd_front`

## Requirements
- R1: All state changes on the rising clock edge. After a synchronous active-high reset, `cmd_code` is 0 (no-op), both banks are idle, the rows and `mode_word` are 0, and `burst_busy`, `wr_en`, `rd_oe` and `proto_err` are 0.
- R2: The pins {cs_n, ras_n, cas_n, we_n} decode as 0111 no-op, 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh and 0000 mode load. Any pattern with cs_n high is a deselect. These report on `cmd_code` as 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode load and 7 deselect. A deselect starts nothing, but a running burst keeps advancing.
- R3: On an edge where `cke` is low, no command is taken, the burst does not advance, and every output keeps its value.
- R4: An activate stores `addr` as the open row of the bank that `bank_sel` names (0 is bank A, 1 is bank B) and marks that bank open (`bank_open` bit 0 is bank A).
- R5: A read or write to an open bank starts a burst of BL beats. The first beat is on the command edge. `burst_col` shows `addr[COL_W-1:0]` after that edge and then goes up by one after each later beat. `burst_busy` is high for exactly BL cycles, while `burst_write` and `burst_bank` show the direction and the bank.
- R6: A precharge with `addr[10]` high closes both banks whatever `bank_sel` is. With `addr[10]` low it closes only the bank that `bank_sel` names.
- R7: A read or write with `addr[10]` high closes its bank on the edge after the final beat, the same edge on which `burst_busy` falls. With `addr[10]` low the bank stays open.
- R8: A read or write to an idle bank raises `proto_err` for one cycle and changes nothing else: no burst starts, and a running burst continues.
- R9: Write mask, zero latency: `wr_en` is high in the cycle after each write-beat edge at which `dqm` was low, and low when `dqm` was high.
- R10: Read mask, two-edge latency: for a read beat at edge k with `dqm` low at edge k, `rd_oe` is high in the cycle after edge k+1. With `dqm` high at edge k it is low.
- R11: A mode load copies `addr` into `mode_word`. A refresh is reported on `cmd_code` and leaves the bank state unchanged.
- R12: A read or write accepted during a burst ends the old burst and starts a new one from its own column and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low suspends the block |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_sel | input | 1 | Bank select (0 = A, 1 = B) |
| addr | input | ROW_W | Row, column and auto-precharge bit (bit 10) |
| dqm | input | 1 | Data mask |
| cmd_code | output | 3 | Last decoded command |
| bank_open | output | 2 | Open flag per bank |
| row_a | output | ROW_W | Open row of bank A |
| row_b | output | ROW_W | Open row of bank B |
| mode_word | output | ROW_W | Last mode-load value |
| burst_busy | output | 1 | Burst in progress |
| burst_write | output | 1 | Burst is a write |
| burst_bank | output | 1 | Bank of the burst |
| burst_col | output | COL_W | Column of the latest beat |
| wr_en | output | 1 | Unmasked write beat |
| rd_oe | output | 1 | Read data output enable |
| proto_err | output | 1 | Access to an idle bank |

## Verification
A wrong open flag shows up on the next access to that bank as a `proto_err` that should not be there, or as a burst that fails to start. It also shows directly on `bank_open` one cycle after the command. A burst counter that is off by one moves the falling edge of `burst_busy` and the auto-precharge close by one cycle. A mask pipeline of the wrong depth shifts the gaps in `rd_oe` by a cycle against the masked beat, which shows within three cycles of that beat. The suspend hold is checked by putting a full command on the pins while `cke` is low and confirming that no output moves.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int NUM_BANKS = 2;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_RD    = 3'd2,
    CMD_WR    = 3'd3,
    CMD_PRE   = 3'd4,
    CMD_REF   = 3'd5,
    CMD_MRS   = 3'd6,
    CMD_DESEL = 3'd7
  } sdc_cmd_e;
endpackage

// File: rtl/sdc_decode.sv
module sdc_decode
  import sdc_pkg::*;
(
  input  logic     cs_n,
  input  logic     ras_n,
  input  logic     cas_n,
  input  logic     we_n,
  output sdc_cmd_e cmd
);
  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP; // burst stop pattern treated as idle
      endcase
    end
  end
endmodule

// File: rtl/sdc_bank.sv
module sdc_bank #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             open_req,
  input  logic             close_req,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row
);
  // an activate on the same edge as a close keeps the bank open with the new row
  always_ff @(posedge clk) begin
    if (rst) begin
      is_open <= 1'b0;
      row     <= '0;
    end else if (en) begin
      if (open_req) begin
        is_open <= 1'b1;
        row     <= row_in;
      end else if (close_req) begin
        is_open <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdc_burst.sv
module sdc_burst #(
  parameter int BL    = 4,
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic             start_write,
  input  logic             start_bank,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_ap,
  input  logic             dqm,
  output logic             busy,
  output logic             is_write,
  output logic             bank,
  output logic [COL_W-1:0] col,
  output logic             ap_fire,
  output logic             wr_en,
  output logic             rd_oe
);
  localparam int CNT_W = (BL > 1) ? $clog2(BL) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BL - 1);

  logic [CNT_W-1:0] cnt;
  logic             ap_pend;
  logic             rd_stage;
  logic             at_last;
  logic             advance;
  logic             beat;
  logic             beat_write;

  assign at_last    = (cnt == LAST_IDX);
  assign advance    = en && busy && !at_last && !start;
  assign beat       = start || advance;
  assign beat_write = start ? start_write : is_write;
  assign ap_fire    = en && busy && at_last && ap_pend && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      is_write <= 1'b0;
      bank     <= 1'b0;
      col      <= '0;
      cnt      <= '0;
      ap_pend  <= 1'b0;
      wr_en    <= 1'b0;
      rd_stage <= 1'b0;
      rd_oe    <= 1'b0;
    end else if (en) begin
      if (start) begin
        busy     <= 1'b1;
        is_write <= start_write;
        bank     <= start_bank;
        col      <= start_col;
        cnt      <= '0;
        ap_pend  <= start_ap;
      end else if (busy) begin
        if (at_last) begin
          busy    <= 1'b0;
          ap_pend <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
          col <= col + 1'b1;
        end
      end
      wr_en    <= beat && beat_write && !dqm;
      rd_stage <= beat && !beat_write && !dqm;
      rd_oe    <= rd_stage;
    end
  end
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdc_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 8,
  parameter int BL     = 4,
  parameter int AP_BIT = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             bank_sel,
  input  logic [ROW_W-1:0] addr,
  input  logic             dqm,
  output logic [2:0]       cmd_code,
  output logic [1:0]       bank_open,
  output logic [ROW_W-1:0] row_a,
  output logic [ROW_W-1:0] row_b,
  output logic [ROW_W-1:0] mode_word,
  output logic             burst_busy,
  output logic             burst_write,
  output logic             burst_bank,
  output logic [COL_W-1:0] burst_col,
  output logic             wr_en,
  output logic             rd_oe,
  output logic             proto_err
);
  sdc_cmd_e         cmd;
  logic             is_rw;
  logic             tgt_open;
  logic             start;
  logic             ap_fire;
  logic [ROW_W-1:0] rows [NUM_BANKS];

  sdc_decode i_decode (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  assign is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign tgt_open = bank_open[bank_sel];
  assign start    = cke && is_rw && tgt_open;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel_here;
    logic open_req;
    logic close_req;
    assign sel_here  = (bank_sel == 1'(b));
    assign open_req  = (cmd == CMD_ACT) && sel_here;
    assign close_req = ((cmd == CMD_PRE) && (addr[AP_BIT] || sel_here)) ||
                       (ap_fire && (burst_bank == 1'(b)));
    sdc_bank #(.ROW_W(ROW_W)) i_bank (
      .clk       (clk),
      .rst       (rst),
      .en        (cke),
      .open_req  (open_req),
      .close_req (close_req),
      .row_in    (addr),
      .is_open   (bank_open[b]),
      .row       (rows[b])
    );
  end

  assign row_a = rows[0];
  assign row_b = rows[1];

  sdc_burst #(.BL(BL), .COL_W(COL_W)) i_burst (
    .clk         (clk),
    .rst         (rst),
    .en          (cke),
    .start       (start),
    .start_write (cmd == CMD_WR),
    .start_bank  (bank_sel),
    .start_col   (addr[COL_W-1:0]),
    .start_ap    (addr[AP_BIT]),
    .dqm         (dqm),
    .busy        (burst_busy),
    .is_write    (burst_write),
    .bank        (burst_bank),
    .col         (burst_col),
    .ap_fire     (ap_fire),
    .wr_en       (wr_en),
    .rd_oe       (rd_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_code  <= CMD_NOP;
      proto_err <= 1'b0;
      mode_word <= '0;
    end else if (cke) begin
      cmd_code  <= cmd;
      proto_err <= is_rw && !tgt_open;
      if (cmd == CMD_MRS) mode_word <= addr;
    end
  end
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             cke,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             bank_sel,
  input logic [ROW_W-1:0] addr,
  input logic [2:0]       cmd_code,
  input logic [1:0]       bank_open,
  input logic             burst_busy,
  input logic             burst_write,
  input logic             wr_en,
  input logic             rd_oe,
  input logic             proto_err
);
  logic [3:0] pins;
  assign pins = {cs_n, ras_n, cas_n, we_n};

  a_r2_deselect_code: assert property (@(posedge clk) disable iff (rst)
    (cke && cs_n) |=> (cmd_code == 3'd7));

  a_r3_suspend_hold: assert property (@(posedge clk) disable iff (rst)
    !cke |=> ($stable(bank_open) && $stable(cmd_code) && $stable(burst_busy)));

  a_r6_precharge_all: assert property (@(posedge clk) disable iff (rst)
    (cke && pins == 4'b0010 && addr[10]) |=> (bank_open == 2'b00));

  a_r8_idle_access_flag: assert property (@(posedge clk) disable iff (rst)
    (cke && (pins == 4'b0101 || pins == 4'b0100) && !bank_open[bank_sel]) |=> proto_err);

  a_r9_write_enable_in_burst: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (burst_busy && burst_write));

  a_r10_read_enable_lag: assert property (@(posedge clk) disable iff (rst)
    rd_oe |-> $past(burst_busy && !burst_write));
endmodule

bind sdram_cmd_front sdc_checker #(.ROW_W(ROW_W)) i_sdc_checker (
  .clk         (clk),
  .rst         (rst),
  .cke         (cke),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .bank_sel    (bank_sel),
  .addr        (addr),
  .cmd_code    (cmd_code),
  .bank_open   (bank_open),
  .burst_busy  (burst_busy),
  .burst_write (burst_write),
  .wr_en       (wr_en),
  .rd_oe       (rd_oe),
  .proto_err   (proto_err)
);

// File: tb/test_sdram_cmd_front.sv
module test_sdram_cmd_front;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 11;
  localparam int COL_W = 8;
  localparam int BL    = 4;

  localparam logic [3:0] P_NOP = 4'b0111;
  localparam logic [3:0] P_ACT = 4'b0011;
  localparam logic [3:0] P_RD  = 4'b0101;
  localparam logic [3:0] P_WR  = 4'b0100;
  localparam logic [3:0] P_PRE = 4'b0010;
  localparam logic [3:0] P_REF = 4'b0001;
  localparam logic [3:0] P_MRS = 4'b0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic bank_sel = 1'b0;
  logic [ROW_W-1:0] addr = '0;
  logic dqm = 1'b0;
  logic [2:0] cmd_code;
  logic [1:0] bank_open;
  logic [ROW_W-1:0] row_a, row_b, mode_word;
  logic burst_busy, burst_write, burst_bank;
  logic [COL_W-1:0] burst_col;
  logic wr_en, rd_oe, proto_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_front #(.ROW_W(ROW_W), .COL_W(COL_W), .BL(BL), .AP_BIT(10)) i_sdram_cmd_front (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .bank_sel(bank_sel), .addr(addr), .dqm(dqm),
    .cmd_code(cmd_code), .bank_open(bank_open), .row_a(row_a), .row_b(row_b),
    .mode_word(mode_word), .burst_busy(burst_busy), .burst_write(burst_write),
    .burst_bank(burst_bank), .burst_col(burst_col), .wr_en(wr_en), .rd_oe(rd_oe),
    .proto_err(proto_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive pins before a rising edge, return after it (at the falling edge)
  task automatic drv(input logic [3:0] p, input logic bs, input int a, input logic dm);
    {cs_n, ras_n, cas_n, we_n} = p;
    bank_sel = bs;
    addr = ROW_W'(a);
    dqm = dm;
    @(negedge clk);
  endtask

  task automatic nop(input logic dm);
    drv(P_NOP, 1'b0, 0, dm);
  endtask

  task automatic t_reset;
    chk("R1 cmd_code", cmd_code, 0);
    chk("R1 bank_open", bank_open, 0);
    chk("R1 burst_busy", burst_busy, 0);
    chk("R1 wr_en", wr_en, 0);
    chk("R1 rd_oe", rd_oe, 0);
    chk("R1 proto_err", proto_err, 0);
    chk("R1 mode_word", mode_word, 0);
  endtask

  task automatic t_activate;
    drv(P_ACT, 1'b0, 'h155, 1'b0);
    chk("R4 open A", bank_open, 2'b01);
    chk("R4 row A", row_a, 'h155);
    chk("R2 act code", cmd_code, 1);
    drv(P_ACT, 1'b1, 'h2AA, 1'b0);
    chk("R4 open B", bank_open, 2'b11);
    chk("R4 row B", row_b, 'h2AA);
    chk("R4 row A kept", row_a, 'h155);
  endtask

  task automatic t_write_burst;
    drv(P_WR, 1'b0, 'h010, 1'b0);
    chk("R5 busy", burst_busy, 1);
    chk("R5 write", burst_write, 1);
    chk("R5 bank", burst_bank, 0);
    chk("R5 col0", burst_col, 'h10);
    chk("R9 beat0 enabled", wr_en, 1);
    nop(1'b1);
    chk("R5 col1", burst_col, 'h11);
    chk("R9 beat1 masked", wr_en, 0);
    nop(1'b0);
    chk("R5 col2", burst_col, 'h12);
    chk("R9 beat2 enabled", wr_en, 1);
    nop(1'b0);
    chk("R5 col3", burst_col, 'h13);
    chk("R5 busy last", burst_busy, 1);
    nop(1'b0);
    chk("R5 busy end", burst_busy, 0);
    chk("R9 no beat", wr_en, 0);
    chk("R7 no autoprecharge", bank_open, 2'b11);
  endtask

  task automatic t_read_ap;
    drv(P_RD, 1'b1, 'h420, 1'b0);
    chk("R5 read dir", burst_write, 0);
    chk("R10 no early oe", rd_oe, 0);
    nop(1'b0);
    chk("R10 beat0 oe", rd_oe, 1);
    chk("R9 read no wr_en", wr_en, 0);
    nop(1'b1);
    chk("R10 beat1 oe", rd_oe, 1);
    chk("R7 still open", bank_open, 2'b11);
    nop(1'b0);
    chk("R10 beat2 masked", rd_oe, 0);
    nop(1'b0);
    chk("R10 beat3 oe", rd_oe, 1);
    chk("R7 busy fell", burst_busy, 0);
    chk("R7 bank B closed", bank_open, 2'b01);
    nop(1'b0);
    chk("R10 oe off", rd_oe, 0);
  endtask

  task automatic t_error;
    drv(P_RD, 1'b1, 'h005, 1'b0);
    chk("R8 flag", proto_err, 1);
    chk("R8 no burst", burst_busy, 0);
    chk("R2 rd code", cmd_code, 2);
    chk("R8 banks same", bank_open, 2'b01);
    nop(1'b0);
    chk("R8 one cycle", proto_err, 0);
  endtask

  task automatic t_precharge;
    drv(P_ACT, 1'b1, 'h0F0, 1'b0);
    chk("R6 setup", bank_open, 2'b11);
    drv(P_PRE, 1'b0, 'h000, 1'b0);
    chk("R6 single bank", bank_open, 2'b10);
    drv(P_ACT, 1'b0, 'h011, 1'b0);
    drv(P_PRE, 1'b0, 'h400, 1'b0);
    chk("R6 all banks", bank_open, 2'b00);
  endtask

  task automatic t_cke;
    drv(P_ACT, 1'b0, 'h123, 1'b0);
    drv(P_WR, 1'b0, 'h050, 1'b0);
    chk("R3 setup col", burst_col, 'h50);
    cke = 1'b0;
    drv(P_ACT, 1'b1, 'h3FF, 1'b0);
    chk("R3 col held", burst_col, 'h50);
    chk("R3 bank held", bank_open, 2'b01);
    chk("R3 code held", cmd_code, 3);
    drv(P_ACT, 1'b1, 'h3FF, 1'b1);
    chk("R3 busy held", burst_busy, 1);
    chk("R3 wr_en held", wr_en, 1);
    cke = 1'b1;
    nop(1'b0);
    chk("R3 resumes", burst_col, 'h51);
    chk("R3 row B untouched", bank_open, 2'b01);
    nop(1'b0);
    nop(1'b0);
    chk("R3 col3", burst_col, 'h53);
    nop(1'b0);
    chk("R3 burst over", burst_busy, 0);
  endtask

  task automatic t_deselect;
    drv(P_WR, 1'b0, 'h060, 1'b0);
    drv(4'b1011, 1'b1, 'h3FF, 1'b0);
    chk("R2 deselect code", cmd_code, 7);
    chk("R2 no activate", bank_open, 2'b01);
    chk("R2 burst continues", burst_col, 'h61);
    nop(1'b0);
    nop(1'b0);
    chk("R2 col3", burst_col, 'h63);
    nop(1'b0);
    chk("R2 burst over", burst_busy, 0);
  endtask

  task automatic t_mode;
    drv(P_MRS, 1'b0, 'h033, 1'b0);
    chk("R11 mode code", cmd_code, 6);
    chk("R11 mode word", mode_word, 'h033);
    drv(P_REF, 1'b0, 'h000, 1'b0);
    chk("R11 refresh code", cmd_code, 5);
    chk("R11 banks same", bank_open, 2'b01);
    chk("R11 mode kept", mode_word, 'h033);
  endtask

  task automatic t_restart;
    drv(P_WR, 1'b0, 'h040, 1'b0);
    nop(1'b0);
    chk("R12 first col1", burst_col, 'h41);
    drv(P_RD, 1'b0, 'h080, 1'b0);
    chk("R12 new dir", burst_write, 0);
    chk("R12 new col", burst_col, 'h80);
    chk("R12 wr_en off", wr_en, 0);
    nop(1'b0);
    nop(1'b0);
    nop(1'b0);
    chk("R12 col3", burst_col, 'h83);
    chk("R12 busy", burst_busy, 1);
    nop(1'b0);
    chk("R12 full length", burst_busy, 0);
    chk("R12 bank open", bank_open, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_activate();
    t_write_burst();
    t_read_ap();
    t_error();
    t_precharge();
    t_cke();
    t_deselect();
    t_mode();
    t_restart();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule